// File: doc/BRIEF.md
# Latch-Based Pulse Stretcher

This block turns a short input pulse into a longer output pulse. The length of the output pulse is set by a separate delay clock, which may run much slower than the system clock. The block has two cells. The first is a set/reset cell: a three-input lookup whose own output is fed back to one of its inputs. A pulse on `pulse_in` sets it, and a delayed copy of its own output clears it. The second cell is a delay stage clocked by `dly_clk`. It passes the latch output through unchanged in logic terms, but with a delay of a fixed number of delay-clock ticks. In the short mode that delay is 2 ticks, taken through a plain synchronizer. In the long mode it is 4 ticks, taken through a filter that accepts a new level only once it has held for two consecutive ticks.

The stretched pulse appears on `pulse_out` in the same cycle that the input arrives; no clock edge lies on that path. When the delayed copy rises it clears the latch, and the delayed copy is also brought out on `dly_out` as a second pulse. A fixed number of ticks after the latch clears, the delayed copy falls, and the block is ready for the next input pulse.

The feedback of the set/reset cell is held in a system-clock register, so an input pulse must cover at least one rising edge of `clk` to stay latched. A policy input chooses what the lookup does when set and clear are both high: force low, force high, or keep the previous output. This choice decides how an input that arrives during recovery is handled. The block has no data stream, so it has no valid/ready handshake. All pins are plain control levels.

Top module: `ps_pulse_stretcher`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `pulse_out` and `dly_out` are both 0.
- R2: When `pulse_in` is high and `dly_out` is low, `pulse_out` is 1 in the same cycle, with no clock edge in between.
- R3: When `pulse_in` and `dly_out` are both low, `pulse_out` keeps the value it held at the previous system-clock edge.
- R4: When `dly_out` is high and `pulse_in` is low, `pulse_out` is 0.
- R5: With `cond_mode`=0 (synchronizer), a single short input pulse gives `pulse_out` high for exactly 2 delay-clock ticks, and then `dly_out` high for exactly 2 ticks.
- R6: With `cond_mode`=1 (filter), a single short input pulse gives `pulse_out` high for exactly 4 delay-clock ticks, and then `dly_out` high for exactly 4 ticks.
- R7: With `policy`=0 (force low), set and clear together drive `pulse_out` to 0. An input held across the whole clear interval therefore gives a first pulse of N ticks, then N ticks low, then a second pulse of N ticks; N is 2 or 4 according to `cond_mode`.
- R8: With `policy`=1 (force high), set and clear together drive `pulse_out` to 1. An input held across the clear interval gives one pulse that lasts until the input is released (2N ticks in the test) and no second pulse.
- R9: With `policy`=2 (hold), set and clear together keep the previous output. An input held through the clear interval therefore behaves as in R8. An input that arrives while the latch is already clear is held off until `dly_out` falls, and then gives a second pulse of N ticks.
- R10: With `policy`=1, an input that arrives during recovery, while `dly_out` is high, drives `pulse_out` high at once.
- R11: `policy`=3 behaves exactly as `policy`=2. No policy code makes the lookup oscillate.
- R12: After `dly_out` has fallen, a new short input pulse is stretched to N ticks again, whatever came before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the latch feedback register |
| rst_n | input | 1 | Active-low asynchronous reset for both clock domains |
| dly_clk | input | 1 | Delay clock, independent of `clk`; its ticks set the pulse width |
| cond_mode | input | 1 | Delay conditioning: 0 selects the synchronizer (2 ticks), 1 selects the filter (4 ticks) |
| policy | input | 2 | Conflict policy when set and clear are both high: 0 force low, 1 force high, 2 or 3 hold |
| pulse_in | input | 1 | Input pulse that sets the latch |
| pulse_out | output | 1 | Stretched pulse, combinational from the latch lookup |
| dly_out | output | 1 | Delayed copy of `pulse_out`; it also clears the latch |

## Verification
The assertions check the lookup on every system-clock cycle: set alone gives a high output, clear alone gives a low output, a quiet input keeps the output, and each conflict policy does its own thing. In the delay domain, an assertion checks that the filter output never changes on two ticks in a row. Pulse widths counted in delay-clock ticks only show up in whole scenarios, and so do the gap before a second pulse, the recovery behaviour of each policy, and the readiness for a new pulse afterwards. The bench measures these with a scoreboard that compares each run length of `pulse_out` and `dly_out` with a queue of expected widths.

// File: rtl/ps_pkg.sv
package ps_pkg;

  // Number of lookup inputs and the width of a truth table for them.
  localparam int LUT_IN = 3;
  localparam int TBL_W  = 1 << LUT_IN;

  // Conflict policy codes, applied when set and clear are both high.
  typedef enum logic [1:0] {
    POL_LOW      = 2'd0,
    POL_HIGH     = 2'd1,
    POL_HOLD     = 2'd2,
    POL_HOLD_ALT = 2'd3
  } conflict_pol_e;

  // Delay conditioning modes.
  typedef enum logic {
    COND_SYNC   = 1'b0,
    COND_FILTER = 1'b1
  } cond_e;

  // The lookup index is {clear, set, feedback}.
  //   idx 1 : feedback only            -> 1 (hold while high)
  //   idx 2,3 : set only               -> 1
  //   idx 0 : nothing                  -> 0 (hold while low)
  //   idx 4,5 : clear only             -> 0
  //   idx 6,7 : set and clear together -> set by the policy
  // The entry pair idx6=1, idx7=0 would invert the feedback and make the
  // cell oscillate, so no policy code produces it.
  function automatic logic [TBL_W-1:0] latch_table(input logic [1:0] pol);
    logic [TBL_W-1:0] t;
    t = 8'b0000_1110;
    case (pol)
      POL_LOW:  t[7:6] = 2'b00;
      POL_HIGH: t[7:6] = 2'b11;
      default:  t[7:6] = 2'b10;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/ps_lut3.sv
module ps_lut3 #(
  parameter int N_IN = 3
) (
  input  logic [(1<<N_IN)-1:0] table_i,
  input  logic [N_IN-1:0]      sel_i,
  output logic                 y_o
);
  // Plain lookup: the output is the table bit addressed by the inputs.
  assign y_o = table_i[sel_i];
endmodule

// File: rtl/ps_latch_cell.sv
module ps_latch_cell
  import ps_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [TBL_W-1:0] table_i,
  output logic             q_o
);
  logic             fb_q;
  logic [LUT_IN-1:0] sel;

  assign sel = {clr_i, set_i, fb_q};

  ps_lut3 #(.N_IN(LUT_IN)) u_lut (
    .table_i (table_i),
    .sel_i   (sel),
    .y_o     (q_o)
  );

  // Feedback register: the lookup output comes back as its own input.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fb_q <= 1'b0;
    else        fb_q <= q_o;
  end

  logic pv_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pv_q <= 1'b0;
    else        pv_q <= 1'b1;
  end

  // R3: with neither set nor clear, the output keeps its previous value.
  a_r3_quiet_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pv_q && !set_i && !clr_i) |-> (q_o == $past(q_o)));

endmodule

// File: rtl/ps_delay_cell.sv
module ps_delay_cell
  import ps_pkg::*;
#(
  parameter int SYNC_TICKS   = 2,
  parameter int FILTER_TICKS = 4
) (
  input  logic dly_clk,
  input  logic rst_n,
  input  logic cond_mode,
  input  logic d_i,
  output logic q_o
);
  // Shift chain: stage k holds the input as it was k+1 ticks ago.
  // The filter register adds one more tick, so the chain needs
  // FILTER_TICKS-1 stages. SYNC_TICKS must be smaller than FILTER_TICKS.
  localparam int CHAIN = FILTER_TICKS - 1;
  localparam int STAP  = SYNC_TICKS - 1;

  logic [CHAIN-1:0] chain_q;
  logic             filt_q;
  logic             sync_tap;
  logic             last_tap;

  always_ff @(posedge dly_clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[CHAIN-2:0], d_i};
  end

  assign sync_tap = chain_q[STAP];
  assign last_tap = chain_q[CHAIN-1];

  // The filter takes a new level only when the synchronized value matches
  // the older tap, i.e. the level has been seen on consecutive ticks.
  always_ff @(posedge dly_clk or negedge rst_n) begin
    if (!rst_n)                    filt_q <= 1'b0;
    else if (sync_tap == last_tap) filt_q <= sync_tap;
  end

  assign q_o = (cond_mode == COND_FILTER) ? filt_q : sync_tap;

  // R6: in filter mode the output never changes on two consecutive ticks.
  a_r6_filter_settles: assert property (@(posedge dly_clk) disable iff (!rst_n)
    (cond_mode && $past(cond_mode) && !$stable(filt_q)) |=> $stable(filt_q));

endmodule

// File: rtl/ps_pulse_stretcher.sv
module ps_pulse_stretcher
  import ps_pkg::*;
#(
  parameter int SYNC_TICKS   = 2,
  parameter int FILTER_TICKS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dly_clk,
  input  logic       cond_mode,
  input  logic [1:0] policy,
  input  logic       pulse_in,
  output logic       pulse_out,
  output logic       dly_out
);
  logic [TBL_W-1:0] tbl;

  assign tbl = latch_table(policy);

  // Latch: set by the input, cleared by its own delayed copy.
  ps_latch_cell u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (pulse_in),
    .clr_i   (dly_out),
    .table_i (tbl),
    .q_o     (pulse_out)
  );

  // Delay stage on the independent delay clock.
  ps_delay_cell #(
    .SYNC_TICKS   (SYNC_TICKS),
    .FILTER_TICKS (FILTER_TICKS)
  ) u_delay (
    .dly_clk   (dly_clk),
    .rst_n     (rst_n),
    .cond_mode (cond_mode),
    .d_i       (pulse_out),
    .q_o       (dly_out)
  );

  logic pv_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pv_q <= 1'b0;
    else        pv_q <= 1'b1;
  end

  // R2: set alone raises the output with no clock in between.
  a_r2_set_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_in && !dly_out) |-> pulse_out);

  // R4: the delayed copy alone clears the output.
  a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_in && dly_out) |-> !pulse_out);

  // R7: force-low policy under conflict.
  a_r7_conflict_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_in && dly_out && policy == POL_LOW) |-> !pulse_out);

  // R8: force-high policy under conflict.
  a_r8_conflict_high: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_in && dly_out && policy == POL_HIGH) |-> pulse_out);

  // R9 and R11: both hold codes keep the previous output under conflict.
  a_r9_conflict_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pv_q && pulse_in && dly_out && policy[1]) |-> (pulse_out == $past(pulse_out)));

endmodule

// File: tb/ps_pulse_stretcher_bench.sv
module ps_pulse_stretcher_bench;

  typedef struct {
    int    width;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       dly_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cond_mode = 1'b0;
  logic [1:0] policy = 2'd0;
  logic       pulse_in = 1'b0;
  logic       pulse_out;
  logic       dly_out;

  int   n_checks = 0;
  int   n_errors = 0;
  exp_t q_p[$];
  exp_t q_d[$];
  int   p_run = 0;
  int   d_run = 0;
  bit   sb_off = 1'b0;

  ps_pulse_stretcher u_ps_pulse_stretcher (
    .clk       (clk),
    .rst_n     (rst_n),
    .dly_clk   (dly_clk),
    .cond_mode (cond_mode),
    .policy    (policy),
    .pulse_in  (pulse_in),
    .pulse_out (pulse_out),
    .dly_out   (dly_out)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Monitor: counts ticks with each output high; on a falling run it pops
  // the next expected width and compares.
  task automatic end_run(input bit is_dly, input int len);
    exp_t e;
    if (sb_off) return;
    if (is_dly) begin
      if (q_d.size() == 0) chk(0, "R12", "unexpected dly_out pulse", len, 0);
      else begin e = q_d.pop_front(); chk(len == e.width, e.tag, "dly_out width", len, e.width); end
    end else begin
      if (q_p.size() == 0) chk(0, "R12", "unexpected pulse_out pulse", len, 0);
      else begin e = q_p.pop_front(); chk(len == e.width, e.tag, "pulse_out width", len, e.width); end
    end
  endtask

  task automatic sample_tick();
    if (!rst_n) return;
    if (pulse_out) p_run++;
    else if (p_run > 0) begin end_run(0, p_run); p_run = 0; end
    if (dly_out) d_run++;
    else if (d_run > 0) begin end_run(1, d_run); d_run = 0; end
  endtask

  // Delay clock, 40 ns period; outputs are sampled 1 ns before each rise.
  initial begin
    forever begin
      #19;
      sample_tick();
      #1 dly_clk = 1'b1;
      #20 dly_clk = 1'b0;
    end
  end

  task automatic push(input int pw, input int dw, input string tag);
    exp_t e;
    e.width = pw; e.tag = tag; q_p.push_back(e);
    e.width = dw; q_d.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    repeat (6*n + 2) @(posedge dly_clk);
    #5;
    chk(q_p.size() == 0 && q_d.size() == 0, tag, "expected pulses missing",
        q_p.size() + q_d.size(), 0);
    chk(!pulse_out && !dly_out, tag, "outputs low when idle",
        {pulse_out, dly_out}, 0);
  endtask

  task automatic short_pulse(input int n, input string tag);
    push(n, n, tag);
    @(posedge dly_clk);
    #12 pulse_in = 1'b1;
    #1 chk(pulse_out == 1'b1, "R2", "immediate rise", pulse_out, 1);
    #9 pulse_in = 1'b0;
    #1 chk(pulse_out == 1'b1, "R3", "held after input falls", pulse_out, 1);
    repeat (n) @(posedge dly_clk);
    #1 chk(!pulse_out && dly_out, "R4", "cleared by delayed copy",
           {pulse_out, dly_out}, 1);
  endtask

  task automatic hold_through(input int n);
    @(posedge dly_clk);
    #12 pulse_in = 1'b1;
    repeat (2*n) @(posedge dly_clk);
    #12 pulse_in = 1'b0;
  endtask

  task automatic during_after(input int n, input bit exp_lvl, input string tag);
    @(posedge dly_clk);
    #12 pulse_in = 1'b1;
    #10 pulse_in = 1'b0;
    repeat (n + 1) @(posedge dly_clk);
    #12 pulse_in = 1'b1;
    #1 chk(pulse_out == exp_lvl, tag, "level on input during recovery",
           pulse_out, exp_lvl);
    repeat (n - 1) @(posedge dly_clk);
    #12 pulse_in = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    string tg;
    int    n;
    // R1: reset state.
    repeat (3) @(posedge clk);
    #1 chk(!pulse_out && !dly_out, "R1", "outputs in reset", {pulse_out, dly_out}, 0);
    repeat (2) @(posedge dly_clk);
    #1 chk(!pulse_out && !dly_out, "R1", "outputs in reset after ticks", {pulse_out, dly_out}, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1 chk(!pulse_out && !dly_out, "R1", "outputs after reset", {pulse_out, dly_out}, 0);

    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < 4; p++) begin
        n = (m == 0) ? 2 : 4;
        cond_mode = m[0];
        policy = p[1:0];
        tg = (m == 0) ? "R5" : "R6";
        short_pulse(n, tg);
        idle(n, tg);

        // Input held across the whole clear interval.
        case (p)
          0: begin tg = "R7"; push(n, n, tg); push(n, n, tg); end
          1: begin tg = "R8"; push(2*n, 2*n, tg); end
          2: begin tg = "R9"; push(2*n, 2*n, tg); end
          default: begin tg = "R11"; push(2*n, 2*n, tg); end
        endcase
        hold_through(n);
        idle(n, tg);

        // Input starting during recovery and lasting past it.
        if (p == 1) begin
          sb_off = 1'b1;
          during_after(n, 1'b1, "R10");
          idle(n, "R10");
          sb_off = 1'b0;
        end else begin
          tg = (p == 0) ? "R7" : (p == 2) ? "R9" : "R11";
          push(n, n, tg);
          push(n, n, tg);
          during_after(n, 1'b0, tg);
          idle(n, tg);
        end

        // Ready again for a fresh pulse.
        short_pulse(n, "R12");
        idle(n, "R12");
      end
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule